// File: doc/BRIEF.md
# Monotone Successive Approximation Time Quantizer

This block is a clocked digital model of a feedforward time-to-digital converter that resolves one bit per clock with a subtraction-free successive approximation. It receives the arrival instants of a signal event and a reference event as unsigned tick counts, together with a one-cycle start strobe. Internally it keeps one running arrival time per event. Each step records which of the two is earlier and then delays that earlier event by a binary-scaled amount. The delays halve from step to step. Neither running time ever decreases, and no weight is ever taken back.

A parameter selects one of two variants. In the one-sided variant the reference is assumed to come first. The reference track is delayed up front by half the conversion range, and the result is the unsigned magnitude of the interval. In the two-sided variant the order of the events is not known in advance. The result is then an offset-binary word whose top bit indicates that the signal event came first. The interval is defined as the reference time minus the signal time. The smallest delay unit, in ticks, is a parameter.

Top module: `mssa_tdc`

## Requirements
- R1: With BIPOLAR=0, the code for interval I = sig_time − ref_time (0 ≤ I < 2^NBITS·UNIT_TICKS) equals floor(I / UNIT_TICKS) as an unsigned NBITS-bit number.
- R2: In every step except the final one, the weight is added only to the track whose running time is strictly smaller. On equality it is added to the reference track. Neither running time ever decreases within a conversion.
- R3: The step that resolves bit k (k ≥ 1) adds exactly UNIT_TICKS·2^(k−1) ticks. Each weight is therefore half the previous one, and the last weight is one unit. The step that resolves bit 0 adds nothing.
- R4: With BIPOLAR=1 the code is offset binary. For x = ref_time − sig_time in the range −2^(NBITS−1)·UNIT_TICKS < x ≤ 2^(NBITS−1)·UNIT_TICKS, code − 2^(NBITS−1) equals ceil(x / UNIT_TICKS) − 1, and bit NBITS−1 is 1 exactly when x > 0. The first weight is a quarter of the span 2^NBITS·UNIT_TICKS.
- R5: Equal running times count as the reference arriving first. With BIPOLAR=1, equal inputs therefore give code 2^(NBITS−1)−1, whose top bit is 0.
- R6: Inputs outside the range saturate. With BIPOLAR=0, I ≥ 2^NBITS·UNIT_TICKS gives all ones and I < 0 gives 0. With BIPOLAR=1, x above the range gives all ones and x at or below its lower end gives 0.
- R7: done is high for exactly one cycle. That cycle is the NBITS-th cycle after the clock edge that accepted start, and code carries the new result in that same cycle.
- R8: A start that arrives while a conversion is in progress is ignored. The ongoing conversion is unchanged and no extra done is produced.
- R9: After reset, code is 0 and done is 0.
- R10: code changes only in the cycle where done is high. Between conversions, including while a new one runs, it holds the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that loads both arrival times when idle |
| sig_time | input | TW | Arrival tick of the signal event |
| ref_time | input | TW | Arrival tick of the reference event |
| code | output | NBITS | Result word, unsigned or offset binary by BIPOLAR |
| done | output | 1 | One-cycle pulse marking a new result on code |

## Verification
Every interval in a contiguous sweep is converted in both variants, from a few ticks below the range to a few ticks above it, with the reference base shifted between conversions. This distinguishes the weight schedule and the decision order from an absolute-time dependence, and it hits both full-scale endpoints. Single conversions with equal times, and with intervals of one tick either side of zero, separate the equality rule from a strict-order comparison and show the sign bit. Further single conversions with reversed order in the one-sided variant, and with far out-of-range values, check saturation. A conversion interrupted by a second start with different times shows whether the strobe is wrongly accepted mid-flight. The timing of done and the hold behaviour of code are checked on every conversion.

// File: rtl/mssa_pkg.sv
package mssa_pkg;

   // Sequencer state: idle waiting for a strobe, or resolving bits.
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } mssa_state_e;

   // Ticks added in the step that resolves bit k (k >= 1); none for bit 0.
   function automatic longint unsigned step_weight(input int unsigned unit,
                                                   input int unsigned k);
      if (k == 0) return 0;
      return longint'(unit) << (k - 1);
   endfunction

endpackage

// File: rtl/mssa_weights.sv
module mssa_weights #(
   parameter int NBITS      = 6,
   parameter int UNIT_TICKS = 3,
   parameter int AW         = 24,
   parameter int SW         = 3
) (
   input  logic [SW-1:0] step,
   output logic [AW-1:0] weight
);
   import mssa_pkg::*;

   logic [AW-1:0] wt_tab [NBITS];

   generate
      if (UNIT_TICKS < 1) begin : g_bad_unit
         $error("mssa_weights: UNIT_TICKS must be at least 1");
      end
      for (genvar k = 0; k < NBITS; k++) begin : g_wt
         localparam logic [AW-1:0] WK = AW'(step_weight(UNIT_TICKS, k));
         assign wt_tab[k] = WK;
      end
   endgenerate

   assign weight = wt_tab[step];

endmodule

// File: rtl/mssa_ctrl.sv
module mssa_ctrl #(
   parameter int NBITS = 6,
   parameter int SW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          load,
   output logic          busy,
   output logic          last,
   output logic [SW-1:0] step,
   output logic          done
);
   import mssa_pkg::*;

   localparam logic [SW-1:0] TOP_STEP = SW'(NBITS - 1);

   mssa_state_e   state_q;
   logic [SW-1:0] step_q;
   logic          done_q;

   generate
      if (NBITS < 2) begin : g_bad_nbits
         $error("mssa_ctrl: NBITS must be at least 2");
      end
   endgenerate

   assign busy = (state_q == ST_RUN);
   assign load = start && (state_q == ST_IDLE);
   assign last = busy && (step_q == '0);
   assign step = step_q;
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         if (load) begin
            state_q <= ST_RUN;
            step_q  <= TOP_STEP;
         end else if (last) begin
            state_q <= ST_IDLE;
         end else if (busy) begin
            step_q <= step_q - 1'b1;
         end
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> done); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last && start) |=> (busy && step_q == $past(step_q) - 1'b1)); // R8

endmodule

// File: rtl/mssa_tracks.sv
module mssa_tracks #(
   parameter int            TW  = 12,
   parameter int            AW  = 24,
   parameter logic [AW-1:0] PRE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          advance,
   input  logic [TW-1:0] sig_time,
   input  logic [TW-1:0] ref_time,
   input  logic [AW-1:0] weight,
   output logic          sig_leads,
   output logic [AW-1:0] sig_acc,
   output logic [AW-1:0] ref_acc
);

   generate
      if (AW <= TW) begin : g_bad_aw
         $error("mssa_tracks: accumulator must be wider than the input");
      end
   endgenerate

   // Strictly earlier signal wins; equality resolves toward the reference.
   assign sig_leads = (sig_acc < ref_acc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_acc <= '0;
         ref_acc <= '0;
      end else if (load) begin
         sig_acc <= AW'(sig_time);
         ref_acc <= AW'(ref_time) + PRE;
      end else if (advance) begin
         if (sig_leads) sig_acc <= sig_acc + weight;
         else           ref_acc <= ref_acc + weight;
      end
   end

   AST_TRACKS_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (sig_acc >= $past(sig_acc)) && (ref_acc >= $past(ref_acc))); // R2
   AST_LEADER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> ($past(sig_leads)
                   ? (sig_acc > $past(sig_acc) && ref_acc == $past(ref_acc))
                   : (ref_acc > $past(ref_acc) && sig_acc == $past(sig_acc)))); // R2

endmodule

// File: rtl/mssa_result.sv
module mssa_result #(
   parameter int NBITS   = 6,
   parameter int SW      = 3,
   parameter bit BIPOLAR = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             busy,
   input  logic             last,
   input  logic [SW-1:0]    step,
   input  logic             sig_leads,
   output logic [NBITS-1:0] code
);

   logic [NBITS-1:0] bits_q;
   logic [NBITS-1:0] word;
   logic [NBITS-1:0] decoded;
   logic [NBITS-1:0] code_q;

   always_comb begin
      word       = bits_q;
      word[step] = sig_leads;
   end

   // One-sided mode: the half-range offset on the reference track makes the
   // raw decision word the complement of the magnitude.
   generate
      if (BIPOLAR) begin : g_offset_bin
         assign decoded = word;
      end else begin : g_magnitude
         assign decoded = ~word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
         code_q <= '0;
      end else if (load) begin
         bits_q <= '0;
      end else if (busy) begin
         bits_q <= word;
         if (last) code_q <= decoded;
      end
   end

   assign code = code_q;

   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> $stable(code_q)); // R10

endmodule

// File: rtl/mssa_tdc.sv
module mssa_tdc #(
   parameter int NBITS      = 6,
   parameter int TW         = 12,
   parameter int UNIT_TICKS = 3,
   parameter bit BIPOLAR    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [TW-1:0]    sig_time,
   input  logic [TW-1:0]    ref_time,
   output logic [NBITS-1:0] code,
   output logic             done
);

   localparam int            SW  = $clog2(NBITS);
   localparam int            AW  = TW + NBITS + $clog2(UNIT_TICKS + 1) + 1;
   localparam logic [AW-1:0] PRE = BIPOLAR ? '0 : (AW'(UNIT_TICKS) << (NBITS - 1));

   generate
      if (NBITS < 2 || NBITS > 16) begin : g_bad_range
         $error("mssa_tdc: NBITS must lie in 2..16");
      end
      if (TW < 2) begin : g_bad_tw
         $error("mssa_tdc: TW must be at least 2");
      end
   endgenerate

   logic          load, busy, last, sig_leads;
   logic [SW-1:0] step;
   logic [AW-1:0] weight, sig_acc, ref_acc;

   mssa_ctrl #(.NBITS(NBITS), .SW(SW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .load(load),
      .busy(busy), .last(last), .step(step), .done(done)
   );

   mssa_weights #(.NBITS(NBITS), .UNIT_TICKS(UNIT_TICKS), .AW(AW), .SW(SW)) u_wt (
      .step(step), .weight(weight)
   );

   mssa_tracks #(.TW(TW), .AW(AW), .PRE(PRE)) u_tracks (
      .clk(clk), .rst_n(rst_n), .load(load), .advance(busy && !last),
      .sig_time(sig_time), .ref_time(ref_time), .weight(weight),
      .sig_leads(sig_leads), .sig_acc(sig_acc), .ref_acc(ref_acc)
   );

   mssa_result #(.NBITS(NBITS), .SW(SW), .BIPOLAR(BIPOLAR)) u_res (
      .clk(clk), .rst_n(rst_n), .load(load), .busy(busy), .last(last),
      .step(step), .sig_leads(sig_leads), .code(code)
   );

   AST_WEIGHT_HALVING: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> ((sig_acc + ref_acc) ==
         $past(sig_acc + ref_acc) + (AW'(UNIT_TICKS) << ($past(step) - 1'b1)))); // R3
   AST_FINAL_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> ($stable(sig_acc) && $stable(ref_acc))); // R3

endmodule

// File: tb/mssa_tdc_tb.sv
`timescale 1ns/1ps
module mssa_tdc_tb;
   localparam int UN = 6, UU = 3, BN = 5, BU = 2, TW = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic su = 1'b0, sb = 1'b0;
   logic [TW-1:0] su_sig = '0, su_ref = '0, sb_sig = '0, sb_ref = '0;
   logic [UN-1:0] code_u;
   logic [BN-1:0] code_b;
   logic done_u, done_b;

   int checks = 0, fails = 0;
   bit finished = 1'b0;
   int q_u[$], q_b[$];
   string t_u[$], t_b[$];
   int prev_u = 0, prev_b = 0;

   mssa_tdc #(.NBITS(UN), .TW(TW), .UNIT_TICKS(UU), .BIPOLAR(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(su), .sig_time(su_sig),
      .ref_time(su_ref), .code(code_u), .done(done_u));

   mssa_tdc #(.NBITS(BN), .TW(TW), .UNIT_TICKS(BU), .BIPOLAR(1'b1)) u_dut_bip (
      .clk(clk), .rst_n(rst_n), .start(sb), .sig_time(sb_sig),
      .ref_time(sb_ref), .code(code_b), .done(done_b));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int floordiv(input int a, input int b);
      return (a >= 0) ? a / b : -((-a + b - 1) / b);
   endfunction

   function automatic int exp_uni(input int s, input int r);
      int i;
      i = s - r;
      if (i < 0) return 0;
      i = i / UU;
      if (i > 2**UN - 1) i = 2**UN - 1;
      return i;
   endfunction

   function automatic int exp_bip(input int s, input int r);
      int v;
      v = floordiv(r - s - 1, BU);
      if (v < -(2**(BN-1))) v = -(2**(BN-1));
      if (v > 2**(BN-1) - 1) v = 2**(BN-1) - 1;
      return v + 2**(BN-1);
   endfunction

   // Scoreboard monitors
   always @(negedge clk) begin
      int e;
      string t;
      if (rst_n && done_u) begin
         if (q_u.size() == 0) check(1'b0, "R8", "unexpected done one-sided", int'(code_u), -1);
         else begin
            e = q_u.pop_front();
            t = t_u.pop_front();
            check(int'(code_u) == e, t, "one-sided code", int'(code_u), e);
         end
      end
   end

   always @(negedge clk) begin
      int e;
      string t;
      if (rst_n && done_b) begin
         if (q_b.size() == 0) check(1'b0, "R8", "unexpected done two-sided", int'(code_b), -1);
         else begin
            e = q_b.pop_front();
            t = t_b.pop_front();
            check(int'(code_b) == e, t, "two-sided code", int'(code_b), e);
         end
      end
   end

   task automatic run_u(input int s, input int r, input string tag, input bit poke);
      int lat, e;
      e = exp_uni(s, r);
      q_u.push_back(e);
      t_u.push_back(tag);
      su_sig = TW'(s);
      su_ref = TW'(r);
      su = 1'b1;
      @(negedge clk);
      su = 1'b0;
      lat = 0;
      while (!done_u && lat < 4 * UN) begin
         @(negedge clk);
         lat++;
         if (poke && lat == 2) begin
            su_sig = TW'(4000);
            su_ref = TW'(1);
            su = 1'b1;
         end else su = 1'b0;
         if (lat == 3) check(int'(code_u) == prev_u, "R10", "one-sided hold while busy", int'(code_u), prev_u);
      end
      su = 1'b0;
      check(lat == UN, "R7", "one-sided latency", lat, UN);
      @(negedge clk);
      check(done_u == 1'b0, "R7", "one-sided done width", int'(done_u), 0);
      check(int'(code_u) == e, "R10", "one-sided hold after done", int'(code_u), e);
      prev_u = e;
   endtask

   task automatic run_b(input int s, input int r, input string tag, input bit poke);
      int lat, e;
      e = exp_bip(s, r);
      q_b.push_back(e);
      t_b.push_back(tag);
      sb_sig = TW'(s);
      sb_ref = TW'(r);
      sb = 1'b1;
      @(negedge clk);
      sb = 1'b0;
      lat = 0;
      while (!done_b && lat < 4 * BN) begin
         @(negedge clk);
         lat++;
         if (poke && lat == 2) begin
            sb_sig = TW'(5);
            sb_ref = TW'(900);
            sb = 1'b1;
         end else sb = 1'b0;
         if (lat == 3) check(int'(code_b) == prev_b, "R10", "two-sided hold while busy", int'(code_b), prev_b);
      end
      sb = 1'b0;
      check(lat == BN, "R7", "two-sided latency", lat, BN);
      @(negedge clk);
      check(done_b == 1'b0, "R7", "two-sided done width", int'(done_b), 0);
      prev_b = e;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(code_u == '0, "R9", "one-sided code after reset", int'(code_u), 0);
      check(done_u == 1'b0, "R9", "one-sided done after reset", int'(done_u), 0);
      check(code_b == '0, "R9", "two-sided code after reset", int'(code_b), 0);
      check(done_b == 1'b0, "R9", "two-sided done after reset", int'(done_b), 0);

      // One-sided: directed points
      run_u(50, 50, "R1 zero interval", 1'b0);
      run_u(67, 50, "R1 mid value", 1'b0);
      run_u(201, 10, "R1 top endpoint", 1'b0);
      run_u(202, 10, "R6 just over range", 1'b0);
      run_u(5, 40, "R6 order reversed", 1'b0);
      run_u(4095, 0, "R6 far over range", 1'b0);
      run_u(4095, 4000, "R1 high base", 1'b0);
      run_u(130, 100, "R8 start ignored", 1'b1);

      // One-sided: contiguous sweep with moving reference base
      for (int i = -3; i <= 195; i++) begin
         int base;
         base = 30 + ((i + 3) * 7) % 60;
         run_u(base + i, base, "R1 R2 R3 sweep", 1'b0);
      end

      // Two-sided: directed points
      run_b(100, 100, "R5 equal arrival", 1'b0);
      check(code_b[BN-1] == 1'b0, "R5", "tie sign bit", int'(code_b[BN-1]), 0);
      run_b(100, 101, "R4 signal first by one", 1'b0);
      check(code_b[BN-1] == 1'b1, "R4", "sign bit signal first", int'(code_b[BN-1]), 1);
      run_b(101, 100, "R4 reference first by one", 1'b0);
      check(code_b[BN-1] == 1'b0, "R4", "sign bit reference first", int'(code_b[BN-1]), 0);
      run_b(100, 132, "R4 upper endpoint", 1'b0);
      run_b(131, 100, "R4 lower endpoint", 1'b0);
      run_b(100, 140, "R6 above range", 1'b0);
      run_b(140, 100, "R6 below range", 1'b0);
      run_b(300, 310, "R8 start ignored", 1'b1);

      // Two-sided: sweep across the whole span
      for (int x = -36; x <= 36; x++) begin
         run_b(200 + (x % 5), 200 + (x % 5) + x, "R2 R3 R4 sweep", 1'b0);
      end

      repeat (5) @(negedge clk);
      check(q_u.size() == 0, "R8", "one-sided results outstanding", q_u.size(), 0);
      check(q_b.size() == 0, "R8", "two-sided results outstanding", q_b.size(), 0);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         finish_run();
      end
   end

endmodule